// File: doc/BRIEF.md
# Programmable Output Advancement Serializer

This block drives one time-division-multiplexed serial output line from per-channel bytes. It keeps a frame counter aligned to an external frame pulse. It turns that count into a channel number and a bit index, and it shifts each channel's byte out, most significant bit first. Four line rates share the same frame length: the rate sets how long a bit lasts and how many channels fit in a frame. The byte for a channel is fetched combinationally: the block presents a channel number and reads the byte back in the same cycle.

Each bit transition on the line can be pulled earlier by 0, 2, 4 or 6 fast-clock cycles. This compensates for the delay that pin loading adds downstream. The lead does not depend on the rate. It is made by adding a fixed offset to the frame count, so the first bit of channel 0 appears before the frame pulse's nominal boundary. The last bit of the final channel ends early by the same amount. Rate and lead settings are taken only when the frame pulse arrives. A frame lasts CHAN_BASE·64·BIT_MIN clocks, which is 16384 clocks (125 µs at 131.072 MHz) with the defaults.

Top module: `adv_tdm_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_out` is driven to 1. The first cycle after reset is released is frame position 0, and the block runs freely from there without any frame pulse.
- R2: Each channel byte is sent most significant bit (bit 7) first and bit 0 last.
- R3: Rate code 0, 1, 2 or 3 makes every bit last BIT_MIN·8, BIT_MIN·4, BIT_MIN·2 or BIT_MIN clocks. With BIT_MIN = 8 these are 64, 32, 16 and 8 clocks, for 2, 4, 8 and 16 Mb/s.
- R4: Channels go out in ascending order from 0. There are CHAN_BASE·2^rate of them per frame, and channel k fills frame positions k·8·P through (k+1)·8·P−1, where P is the bit length.
- R5: With lead code c, `ser_out` in the cycle at frame position k carries the bit for position (k + 2c) mod frame length. So bit 7 of channel 0 starts 2c clocks before the nominal frame boundary, and the final bit of the last channel ends 2c clocks early.
- R6: `rate_sel` and `lead_code` are sampled only in the cycle where `frame_pulse` is high. Changing them at any other time leaves the stream unchanged until the next pulse.
- R7: A clock edge with `frame_pulse` high makes the following cycle frame position 0, wherever the count stood before. Without a pulse the count wraps by itself after one frame length.
- R8: `chan_idx` is the channel whose bit `ser_out` will show in the next cycle, and `chan_byte` is sampled for that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Frame alignment pulse; the next cycle is frame position 0 |
| rate_sel | input | 2 | Line rate code, taken at the frame pulse |
| lead_code | input | 2 | Advancement code c (lead of 2c clocks), taken at the frame pulse |
| chan_idx | output | $clog2(CHAN_BASE*8) | Channel number of the byte needed next |
| chan_byte | input | 8 | Byte for `chan_idx`, read in the same cycle |
| ser_out | output | 1 | Serial data line |

## Verification
All sixteen combinations of rate and lead code are run with a distinct byte pattern each. Every cycle of a settled frame is compared with a position model, so a wrong bit length, a wrong bit order or a wrong channel count shows up as a stream mismatch. The pattern forces the final bit of each possible last channel to 0 and bit 7 of channel 0 to 1, so the clock at which the line rises before the frame boundary gives the lead directly and separates lead codes 0, 1, 2 and 3. Directed runs then cover three cases. A change of settings in the middle of a frame must leave that frame untouched. A frame pulse arriving early must realign the stream. Reset must give a free-running frame starting from position 0.

// File: rtl/adv_ser_pkg.sv
package adv_ser_pkg;

    // Line rate codes; a higher code halves the bit length.
    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_16M = 2'd3
    } line_rate_e;

    typedef struct packed {
        line_rate_e rate;
        logic [1:0] lead_code;
    } stream_cfg_t;

    localparam stream_cfg_t CFG_RESET = '{rate: RATE_2M, lead_code: 2'd0};

    // Lead in system clocks for a given code: two clocks per step.
    function automatic logic [2:0] lead_clocks(input logic [1:0] code);
        return {code, 1'b0};
    endfunction

    // log2 of the bit length in clocks for a rate.
    function automatic int unsigned bit_len_log2(input line_rate_e r, input int unsigned lg_bit_min);
        return lg_bit_min + 3 - int'(r);
    endfunction

endpackage

// File: rtl/adv_frame_timer.sv
module adv_frame_timer
    import adv_ser_pkg::*;
#(
    parameter int POS_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_pulse,
    input  stream_cfg_t      cfg_req,
    output stream_cfg_t      cfg_now,
    output logic [POS_W-1:0] pos_next
);

    logic [POS_W-1:0] frame_cnt;
    logic [POS_W-1:0] cnt_next;
    stream_cfg_t      cfg_hold;

    // Next frame count, settings in force at this edge, and the advanced position.
    always_comb begin
        cnt_next = frame_pulse ? '0 : frame_cnt + 1'b1;
        cfg_now  = frame_pulse ? cfg_req : cfg_hold;
        pos_next = cnt_next + POS_W'(lead_clocks(cfg_now.lead_code));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '1;
            cfg_hold  <= CFG_RESET;
        end else begin
            frame_cnt <= cnt_next;
            cfg_hold  <= cfg_now;
        end
    end

    // The pulse restarts the frame at position 0.
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> (frame_cnt == '0));

    // Outside the pulse the settings do not move.
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !frame_pulse |=> (frame_pulse || cfg_now == $past(cfg_now)));

endmodule

// File: rtl/adv_slot_decoder.sv
module adv_slot_decoder
    import adv_ser_pkg::*;
#(
    parameter int POS_W      = 14,
    parameter int CH_W       = 8,
    parameter int LG_BIT_MIN = 3
) (
    input  logic [POS_W-1:0] pos_next,
    input  line_rate_e       rate,
    output logic [CH_W-1:0]  chan,
    output logic [2:0]       bit_sel
);

    logic [POS_W-1:0] slot;

    // Position -> bit slot -> (channel, bit index, MSB first).
    always_comb begin
        slot    = pos_next >> bit_len_log2(rate, LG_BIT_MIN);
        chan    = CH_W'(slot >> 3);
        bit_sel = 3'd7 - slot[2:0];
    end

endmodule

// File: rtl/adv_bit_driver.sv
module adv_bit_driver (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] chan_byte,
    input  logic [2:0] bit_sel,
    output logic       ser_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out <= 1'b1;
        end else begin
            ser_out <= chan_byte[bit_sel];
        end
    end

    // Line idles high through reset.
    assert_idle_high_R1: assert property (@(posedge clk)
        rst |=> ser_out);

endmodule

// File: rtl/adv_tdm_serializer.sv
module adv_tdm_serializer
    import adv_ser_pkg::*;
#(
    parameter int CHAN_BASE = 32,
    parameter int BIT_MIN   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           frame_pulse,
    input  logic [1:0]                     rate_sel,
    input  logic [1:0]                     lead_code,
    output logic [$clog2(CHAN_BASE*8)-1:0] chan_idx,
    input  logic [7:0]                     chan_byte,
    output logic                           ser_out
);

    localparam int LG_BIT_MIN = $clog2(BIT_MIN);
    localparam int CH_W       = $clog2(CHAN_BASE * 8);
    localparam int POS_W      = $clog2(CHAN_BASE * 64 * BIT_MIN);

    // The largest lead (6 clocks) must stay shorter than the shortest bit.
    if (BIT_MIN < 8 || (BIT_MIN & (BIT_MIN - 1)) != 0) begin : g_bad_bit_min
        $error("BIT_MIN must be a power of two of at least 8");
    end
    if (CHAN_BASE < 1 || (CHAN_BASE & (CHAN_BASE - 1)) != 0) begin : g_bad_chan_base
        $error("CHAN_BASE must be a power of two");
    end

    stream_cfg_t      cfg_req;
    stream_cfg_t      cfg_now;
    logic [POS_W-1:0] pos_next;
    logic [2:0]       bit_sel;

    always_comb begin
        cfg_req.rate      = line_rate_e'(rate_sel);
        cfg_req.lead_code = lead_code;
    end

    adv_frame_timer #(
        .POS_W (POS_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .cfg_req     (cfg_req),
        .cfg_now     (cfg_now),
        .pos_next    (pos_next)
    );

    adv_slot_decoder #(
        .POS_W      (POS_W),
        .CH_W       (CH_W),
        .LG_BIT_MIN (LG_BIT_MIN)
    ) u_decoder (
        .pos_next (pos_next),
        .rate     (cfg_now.rate),
        .chan     (chan_idx),
        .bit_sel  (bit_sel)
    );

    adv_bit_driver u_driver (
        .clk       (clk),
        .rst       (rst),
        .chan_byte (chan_byte),
        .bit_sel   (bit_sel),
        .ser_out   (ser_out)
    );

    // Channel number stays inside the count for the rate in force.
    assert_chan_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(chan_idx) < (CHAN_BASE << int'(cfg_now.rate)));

    // At the pulse the byte wanted is channel 0 (lead is under one bit).
    assert_ch0_at_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> (chan_idx == '0));

    // The first bit after the pulse is bit 7 of that byte.
    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> (ser_out == $past(chan_byte[7])));

endmodule

// File: tb/adv_tdm_serializer_bench.sv
module adv_tdm_serializer_bench;

    localparam int CHAN_BASE = 2;
    localparam int BIT_MIN   = 8;
    localparam int FRAME     = CHAN_BASE * 64 * BIT_MIN;
    localparam int CH_W      = $clog2(CHAN_BASE * 8);

    typedef struct packed {
        logic [1:0] rate;
        logic [1:0] lead;
        logic [7:0] seed;
        logic [2:0] exp_lead;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'd0, 2'd0, 8'h13, 3'd0}, '{2'd0, 2'd1, 8'h2A, 3'd2},
        '{2'd0, 2'd2, 8'h47, 3'd4}, '{2'd0, 2'd3, 8'h5C, 3'd6},
        '{2'd1, 2'd3, 8'h61, 3'd6}, '{2'd1, 2'd0, 8'h7E, 3'd0},
        '{2'd1, 2'd2, 8'h88, 3'd4}, '{2'd1, 2'd1, 8'h95, 3'd2},
        '{2'd2, 2'd1, 8'hA3, 3'd2}, '{2'd2, 2'd3, 8'hB6, 3'd6},
        '{2'd2, 2'd0, 8'hC9, 3'd0}, '{2'd2, 2'd2, 8'hD4, 3'd4},
        '{2'd3, 2'd2, 8'hE1, 3'd4}, '{2'd3, 2'd0, 8'hF7, 3'd0},
        '{2'd3, 2'd1, 8'h0B, 3'd2}, '{2'd3, 2'd3, 8'h3D, 3'd6}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            frame_pulse = 1'b0;
    logic [1:0]      rate_sel = 2'd0;
    logic [1:0]      lead_code = 2'd0;
    logic [CH_W-1:0] chan_idx;
    logic [7:0]      chan_byte;
    logic            ser_out;
    logic [7:0]      seed = 8'h00;
    logic            zero_src = 1'b1;
    int              n_checks = 0;
    int              n_errors = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    // Byte source: channel 0 has bit 7 = 1, every possible last channel has bit 0 = 0.
    function automatic logic [7:0] pat(input logic [7:0] s, input int ch);
        logic [7:0] b;
        b = 8'(ch * 29) ^ s ^ 8'(ch << 5);
        if (((ch + 1) & ch) == 0) b[0] = 1'b0;
        if (ch == 0) b[7] = 1'b1;
        return b;
    endfunction

    always_comb chan_byte = zero_src ? 8'h00 : pat(seed, int'(chan_idx));

    adv_tdm_serializer #(
        .CHAN_BASE (CHAN_BASE),
        .BIT_MIN   (BIT_MIN)
    ) u_adv_tdm_serializer (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .rate_sel    (rate_sel),
        .lead_code   (lead_code),
        .chan_idx    (chan_idx),
        .chan_byte   (chan_byte),
        .ser_out     (ser_out)
    );

    function automatic int chan_at(input int pos, input int rate);
        int bp;
        bp = BIT_MIN << (3 - rate);
        return (pos / bp) / 8;
    endfunction

    function automatic logic bit_at(input int pos, input int rate, input logic [7:0] s);
        int bp;
        int slot;
        logic [7:0] b;
        bp   = BIT_MIN << (3 - rate);
        slot = pos / bp;
        b    = pat(s, slot / 8);
        return b[7 - (slot % 8)];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at the negedge right after a pulse edge (position 0); ends at the next such negedge.
    task automatic run_frame(input int m_rate, input int m_lead, input logic [7:0] m_seed,
                             input bit mid_change, input int new_rate, input int new_lead,
                             output int bit_err, output int chan_err, output int lead_seen);
        bit_err   = 0;
        chan_err  = 0;
        lead_seen = 0;
        for (int k = 0; k < FRAME; k++) begin
            int p;
            int pn;
            p  = (k + 2 * m_lead) % FRAME;
            pn = (k + 1 + 2 * m_lead) % FRAME;
            if (ser_out !== bit_at(p, m_rate, m_seed)) bit_err++;
            if (int'(chan_idx) != chan_at(pn, m_rate)) chan_err++;
            if (lead_seen == 0 && k >= FRAME - 7 && ser_out === 1'b1) lead_seen = FRAME - k;
            if (mid_change && k == FRAME / 2) begin
                rate_sel  = 2'(new_rate);
                lead_code = 2'(new_lead);
            end
            frame_pulse = (k == FRAME - 1);
            @(negedge clk);
        end
        frame_pulse = 1'b0;
    endtask

    initial begin
        int be;
        int ce;
        int ls;
        // R1: idle high during reset, even with all-zero bytes
        repeat (3) @(negedge clk);
        check(ser_out === 1'b1, "R1 idle during reset", int'(ser_out), 1);
        zero_src = 1'b0;
        seed     = 8'h3C;
        rst      = 1'b0;
        @(negedge clk);
        // R1: free-running frame from position 0 with default settings
        run_frame(0, 0, 8'h3C, 1'b0, 0, 0, be, ce, ls);
        check(be == 0, "R1 stream after reset", be, 0);

        // Table of rate/lead combinations
        for (int i = 0; i < 16; i++) begin
            rate_sel  = VECS[i].rate;
            lead_code = VECS[i].lead;
            seed      = VECS[i].seed;
            run_frame(0, 0, VECS[i].seed, 1'b0, 0, 0, be, ce, ls);
            run_frame(int'(VECS[i].rate), int'(VECS[i].lead), VECS[i].seed, 1'b0, 0, 0, be, ce, ls);
            check(be == 0, $sformatf("R2/R3/R4 stream vec %0d", i), be, 0);
            check(ce == 0, $sformatf("R8 channel index vec %0d", i), ce, 0);
            check(ls == int'(VECS[i].exp_lead), $sformatf("R5 lead clocks vec %0d", i),
                  ls, int'(VECS[i].exp_lead));
        end

        // R6: mid-frame change ignored until the pulse (settings now rate 3, lead 3)
        seed = 8'h5A;
        run_frame(3, 3, 8'h5A, 1'b1, 0, 1, be, ce, ls);
        check(be == 0, "R6 mid-frame change ignored", be, 0);
        check(ls == 6, "R6 old lead kept", ls, 6);
        run_frame(0, 1, 8'h5A, 1'b0, 0, 0, be, ce, ls);
        check(be == 0, "R6 new settings after pulse", be, 0);
        check(ls == 2, "R6 new lead after pulse", ls, 2);

        // R7: early pulse realigns the frame
        for (int k = 0; k < 300; k++) begin
            frame_pulse = (k == 299);
            @(negedge clk);
        end
        frame_pulse = 1'b0;
        run_frame(0, 1, 8'h5A, 1'b0, 0, 0, be, ce, ls);
        check(be == 0, "R7 stream after early pulse", be, 0);
        check(ce == 0, "R7 channel index after early pulse", ce, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule